// File: doc/BRIEF.md
# Dual Mask Register Unit

This block keeps two independent bit masks and applies whichever one is selected to the two masked operations of a content-addressable memory: a search, where masked bits of the search key are excluded from matching, and a write, where masked bits of the destination keep their old value. The memory array, the key storage and the command decoder live elsewhere. They reach this block only through the key, the old destination value and the new write data.

The first mask has a working copy and a spare copy. A single-cycle exchange swaps them, so software can switch between two masking contexts without reloading. Only the working copy is ever applied. The second mask has no spare copy. Instead it can be moved one bit toward the most significant end or toward the least significant end on each command. A mask bit of 1 always means "masked". All outputs are combinational functions of the registered masks and the current inputs.

Top module: `dmask_unit`

## Requirements
- R1: After synchronous reset, the working copy, the spare copy and the second mask are all zero, so the active mask reads 0 under either selection.
- R2: With `mask_sel` = 0 the active mask is the working copy of mask 1. With `mask_sel` = 1 it is mask 2.
- R3: A `m1_load` pulse writes `load_data` into the working copy of mask 1 at the next clock edge and leaves the spare copy unchanged.
- R4: A `m1_swap` pulse without `m1_load` exchanges the working and spare copies of mask 1 in one clock. The spare copy only becomes visible through a swap.
- R5: When `m1_load` and `m1_swap` are high in the same cycle, the load takes effect and the swap is ignored.
- R6: A `m2_load` pulse writes `load_data` into mask 2 at the next clock edge.
- R7: `m2_shl` alone moves mask 2 one place toward bit W-1. Bit 0 becomes 0 and the old bit W-1 is lost.
- R8: `m2_shr` alone moves mask 2 one place toward bit 0. Bit W-1 becomes 0 and the old bit 0 is lost.
- R9: `m2_load` overrides either shift command. `m2_shl` and `m2_shr` together, without a load, leave mask 2 unchanged.
- R10: `cmp_enable` equals the inverse of the active mask, and `cmp_key` equals `comparand` with every masked bit forced to 0.
- R11: `write_merged` equals `(dest_old & mask) | (write_data & ~mask)` for the active mask.
- R12: Commands for one mask never change the other mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mask_sel | input | 1 | 0 selects mask 1 working copy, 1 selects mask 2 |
| m1_load | input | 1 | Load working copy of mask 1 from load_data |
| m1_swap | input | 1 | Exchange working and spare copies of mask 1 |
| m2_load | input | 1 | Load mask 2 from load_data |
| m2_shl | input | 1 | Shift mask 2 one bit toward the MSB |
| m2_shr | input | 1 | Shift mask 2 one bit toward the LSB |
| load_data | input | W | Value for mask loads |
| comparand | input | W | Search key |
| dest_old | input | W | Current destination contents |
| write_data | input | W | New data for a masked write |
| active_mask | output | W | Mask currently applied |
| cmp_enable | output | W | 1 where the key bit takes part in matching |
| cmp_key | output | W | Key with masked bits cleared |
| write_merged | output | W | Destination after a masked write |

## Verification
Directed sequences cover the reset value, a load and a swap of mask 1 followed by a return swap, a load and a swap issued together, and mask 2 shifts from a pattern holding both end bits set. These shifts show whether the vacated bit is refilled with 0 and whether the far-end bit is dropped. Conflicting shift commands and a load issued together with a shift test the priority rules. Between these steps, reading the other selection shows that neither mask disturbs the other. A long run of random command mixes, masks and data words then checks the compare and merge outputs against bench models, and catches any bit that leaks across the mask boundary in either direction.

// File: rtl/dmask_pkg.sv
package dmask_pkg;

    localparam int DEFAULT_WIDTH = 16;

    typedef enum logic {
        MSEL_PRIMARY = 1'b0,
        MSEL_SHIFTER = 1'b1
    } mask_sel_e;

    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_LOAD  = 2'd1,
        SH_LEFT  = 2'd2,
        SH_RIGHT = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        BK_HOLD = 2'd0,
        BK_LOAD = 2'd1,
        BK_SWAP = 2'd2
    } bank_op_e;

    function automatic shift_op_e decode_shift(input logic ld, input logic lft, input logic rgt);
        if (ld)
            return SH_LOAD;
        else if (lft && !rgt)
            return SH_LEFT;
        else if (rgt && !lft)
            return SH_RIGHT;
        else
            return SH_HOLD;
    endfunction

    function automatic bank_op_e decode_bank(input logic ld, input logic sw);
        if (ld)
            return BK_LOAD;
        else if (sw)
            return BK_SWAP;
        else
            return BK_HOLD;
    endfunction

endpackage

// File: rtl/dmask_bank.sv
module dmask_bank
    import dmask_pkg::*;
#(
    parameter int W = DEFAULT_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         swap,
    input  logic [W-1:0] din,
    output logic [W-1:0] fg
);

    logic [W-1:0] bg;
    bank_op_e     op;

    assign op = decode_bank(load, swap);

    always_ff @(posedge clk) begin
        if (rst) begin
            fg <= '0;
            bg <= '0;
        end else begin
            case (op)
                BK_LOAD: fg <= din;
                BK_SWAP: begin
                    fg <= bg;
                    bg <= fg;
                end
                default: ;
            endcase
        end
    end

    AST_BANK_RESET: assert property (@(posedge clk) rst |=> (fg == '0 && bg == '0)); // R1

    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (fg == $past(din) && bg == $past(bg))); // R5

    AST_BANK_SWAP: assert property (@(posedge clk) disable iff (rst)
        (swap && !load) |=> (fg == $past(bg) && bg == $past(fg))); // R4

    AST_BANK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!swap && !load) |=> $stable(fg)); // R12

endmodule

// File: rtl/dmask_shifter.sv
module dmask_shifter
    import dmask_pkg::*;
#(
    parameter int W = DEFAULT_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shl,
    input  logic         shr,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    shift_op_e op;

    assign op = decode_shift(load, shl, shr);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                SH_LOAD:  q <= din;
                SH_LEFT:  q <= {q[W-2:0], 1'b0};
                SH_RIGHT: q <= {1'b0, q[W-1:1]};
                default:  ;
            endcase
        end
    end

    AST_SHIFT_RESET: assert property (@(posedge clk) rst |=> (q == '0)); // R1

    AST_SHIFT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(din))); // R9

    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (shl && !shr && !load) |=> (q[0] == 1'b0 && q[W-1:1] == $past(q[W-2:0]))); // R7

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (shr && !shl && !load) |=> (q[W-1] == 1'b0 && q[W-2:0] == $past(q[W-1:1]))); // R8

    AST_SHIFT_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        (shl && shr && !load) |=> $stable(q)); // R9

endmodule

// File: rtl/dmask_apply.sv
module dmask_apply
    import dmask_pkg::*;
#(
    parameter int W = DEFAULT_WIDTH
) (
    input  logic [W-1:0] mask,
    input  logic [W-1:0] comparand,
    input  logic [W-1:0] dest_old,
    input  logic [W-1:0] write_data,
    output logic [W-1:0] cmp_enable,
    output logic [W-1:0] cmp_key,
    output logic [W-1:0] write_merged
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign cmp_enable[i]   = ~mask[i];
        assign cmp_key[i]      = comparand[i] & ~mask[i];
        assign write_merged[i] = mask[i] ? dest_old[i] : write_data[i];
    end

    always_comb begin
        AST_MERGE_KEEPS_MASKED: assert (((write_merged ^ dest_old) & mask) == '0); // R11
        AST_MERGE_TAKES_OPEN: assert (((write_merged ^ write_data) & ~mask) == '0); // R11
        AST_KEY_CLEARED: assert ((cmp_key & mask) == '0); // R10
    end

endmodule

// File: rtl/dmask_unit.sv
module dmask_unit
    import dmask_pkg::*;
#(
    parameter int W = DEFAULT_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_sel,
    input  logic         m1_load,
    input  logic         m1_swap,
    input  logic         m2_load,
    input  logic         m2_shl,
    input  logic         m2_shr,
    input  logic [W-1:0] load_data,
    input  logic [W-1:0] comparand,
    input  logic [W-1:0] dest_old,
    input  logic [W-1:0] write_data,
    output logic [W-1:0] active_mask,
    output logic [W-1:0] cmp_enable,
    output logic [W-1:0] cmp_key,
    output logic [W-1:0] write_merged
);

    logic [W-1:0] m1_fg;
    logic [W-1:0] m2_q;
    mask_sel_e    sel;

    assign sel = mask_sel_e'(mask_sel);

    dmask_bank #(.W(W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .load (m1_load),
        .swap (m1_swap),
        .din  (load_data),
        .fg   (m1_fg)
    );

    dmask_shifter #(.W(W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (m2_load),
        .shl  (m2_shl),
        .shr  (m2_shr),
        .din  (load_data),
        .q    (m2_q)
    );

    always_comb begin
        case (sel)
            MSEL_SHIFTER: active_mask = m2_q;
            default:      active_mask = m1_fg;
        endcase
    end

    dmask_apply #(.W(W)) u_apply (
        .mask         (active_mask),
        .comparand    (comparand),
        .dest_old     (dest_old),
        .write_data   (write_data),
        .cmp_enable   (cmp_enable),
        .cmp_key      (cmp_key),
        .write_merged (write_merged)
    );

    AST_M2_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (!m2_load && !m2_shl && !m2_shr) |=> $stable(m2_q)); // R12

endmodule

// File: tb/dmask_unit_bench.sv
module dmask_unit_bench;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 400;

    logic         clk = 1'b0;
    logic         rst;
    logic         mask_sel, m1_load, m1_swap, m2_load, m2_shl, m2_shr;
    logic [W-1:0] load_data, comparand, dest_old, write_data;
    logic [W-1:0] active_mask, cmp_enable, cmp_key, write_merged;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [W-1:0] mod_fg, mod_bg, mod_m2;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmask_unit #(.W(W)) u_dmask_unit (
        .clk(clk), .rst(rst), .mask_sel(mask_sel),
        .m1_load(m1_load), .m1_swap(m1_swap),
        .m2_load(m2_load), .m2_shl(m2_shl), .m2_shr(m2_shr),
        .load_data(load_data), .comparand(comparand),
        .dest_old(dest_old), .write_data(write_data),
        .active_mask(active_mask), .cmp_enable(cmp_enable),
        .cmp_key(cmp_key), .write_merged(write_merged)
    );

    function automatic logic [W-1:0] exp_merge(logic [W-1:0] m, logic [W-1:0] o, logic [W-1:0] n);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = m[i] ? o[i] : n[i];
        return r;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        m1_load = 0; m1_swap = 0; m2_load = 0; m2_shl = 0; m2_shr = 0;
    endtask

    // Look at the selected mask between edges (no clock edge involved).
    task automatic peek(logic s, logic [W-1:0] exp, string tag);
        idle_inputs();
        mask_sel = s;
        #1;
        chk(tag, active_mask, exp);
    endtask

    // Apply one command cycle and update the bench model at the edge.
    task automatic cyc(logic l1, logic sw, logic l2, logic sl, logic sr, logic [W-1:0] d);
        m1_load = l1; m1_swap = sw; m2_load = l2; m2_shl = sl; m2_shr = sr;
        load_data = d;
        @(posedge clk);
        if (l1) mod_fg = d;
        else if (sw) begin
            logic [W-1:0] t;
            t = mod_fg; mod_fg = mod_bg; mod_bg = t;
        end
        if (l2) mod_m2 = d;
        else if (sl && !sr) mod_m2 = {mod_m2[W-2:0], 1'b0};
        else if (sr && !sl) mod_m2 = {1'b0, mod_m2[W-1:1]};
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; idle_inputs(); mask_sel = 0;
        load_data = '0; comparand = '0; dest_old = '0; write_data = '0;
        mod_fg = '0; mod_bg = '0; mod_m2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state, both selections and the spare copy
        peek(0, '0, "R1 mask1 after reset");
        peek(1, '0, "R1 mask2 after reset");
        cyc(0, 1, 0, 0, 0, '0);
        peek(0, '0, "R1 spare copy after reset");

        // R3 load working copy, R4 swap both ways
        cyc(1, 0, 0, 0, 0, 16'hA5A5);
        peek(0, 16'hA5A5, "R3 mask1 load");
        peek(1, 16'h0000, "R2 R12 mask2 unaffected by mask1 load");
        cyc(0, 1, 0, 0, 0, '0);
        peek(0, 16'h0000, "R4 swap brings spare forward");
        cyc(0, 1, 0, 0, 0, '0);
        peek(0, 16'hA5A5, "R4 swap back");

        // R5 load wins over swap
        cyc(1, 1, 0, 0, 0, 16'h1234);
        peek(0, 16'h1234, "R5 load with swap");
        cyc(0, 1, 0, 0, 0, '0);
        peek(0, 16'h0000, "R5 spare kept after load+swap");

        // R6 load mask2, R7 left, R8 right
        cyc(0, 0, 1, 0, 0, 16'h8001);
        peek(1, 16'h8001, "R6 mask2 load");
        peek(0, mod_fg, "R12 mask1 unaffected by mask2 load");
        cyc(0, 0, 0, 1, 0, '0);
        peek(1, 16'h0002, "R7 shift left drops MSB fills 0");
        cyc(0, 0, 1, 0, 0, 16'h8001);
        cyc(0, 0, 0, 0, 1, '0);
        peek(1, 16'h4000, "R8 shift right drops LSB fills 0");

        // R9 conflicts
        cyc(0, 0, 0, 1, 1, '0);
        peek(1, 16'h4000, "R9 both shifts hold");
        cyc(0, 0, 1, 1, 0, 16'h0F0F);
        peek(1, 16'h0F0F, "R9 load over left shift");
        cyc(0, 0, 1, 0, 1, 16'hF00F);
        peek(1, 16'hF00F, "R9 load over right shift");
        peek(0, mod_fg, "R12 mask1 unaffected by mask2 shifts");

        // R10 R11 directed, all-ones mask and all-zero mask
        cyc(1, 0, 0, 0, 0, 16'hFFFF);
        mask_sel = 0; comparand = 16'hBEEF; dest_old = 16'h1357; write_data = 16'hCAFE; #1;
        chk("R10 key fully masked", cmp_key, 16'h0000);
        chk("R11 merge all masked keeps old", write_merged, 16'h1357);
        cyc(1, 0, 0, 0, 0, 16'h0000);
        mask_sel = 0; #1;
        chk("R10 enable all open", cmp_enable, 16'hFFFF);
        chk("R11 merge none masked takes new", write_merged, 16'hCAFE);

        // Random mix
        for (int k = 0; k < N_RANDOM; k++) begin
            logic [W-1:0] exp_m;
            mask_sel   = $urandom_range(0, 1);
            comparand  = W'($urandom);
            dest_old   = W'($urandom);
            write_data = W'($urandom);
            #1;
            exp_m = mask_sel ? mod_m2 : mod_fg;
            chk(mask_sel ? "R2 R6-R9 mask2 select" : "R2 R3-R5 mask1 select", active_mask, exp_m);
            chk("R10 cmp_enable", cmp_enable, ~exp_m);
            chk("R10 cmp_key", cmp_key, comparand & ~exp_m);
            chk("R11 write_merged", write_merged, exp_merge(exp_m, dest_old, write_data));
            cyc($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0,
                $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1,
                $urandom_range(0, 1) == 1, W'($urandom));
        end

        summary();
    end

endmodule